// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This block brings a multi-port device from fundamental reset to a configured state. Once reset is released it captures a set of static strap inputs: the operating mode, the number of the upstream port, and a lane-width code for every port. It places them in a small bank of 32-bit configuration registers. When the active-low presence input shows that an external serial configuration memory is attached, the sequencer pulls a byte stream from a simple byte-read interface. That stream is a record count followed by address/data records, and each record is written into the register bank. A record may replace the value that the straps supplied.

The physical layer is held off until every configuration source has finished. Only then does `link_en` rise, and `init_done` follows one cycle later. Once `init_done` is high, the runtime write port may change the writable registers. The registers flagged read-only by a mask keep their values. A byte source that stalls is caught by a programmable timeout. The timeout raises a sticky error flag and still lets link bring-up go ahead.

Top module: `cfg_init_seq`

## Requirements
- R1: While `rst_n` is low, `link_en`, `init_done`, `load_err` and `rd_req` are low and every register in the bank reads zero.
- R2: The straps are captured on the second rising edge after `rst_n` goes high. Register 0 then holds `{strap_lanes, strap_upport, strap_mode}`, zero-extended, with mode in the lowest bits and port i's lane code at bit MODE_W+UP_W+i*LANE_W. The straps are not sampled again until the next reset.
- R3: With `rom_present_n` high, `rd_req` never rises, `link_en` rises on the third rising edge after reset release, and `init_done` rises on the fourth.
- R4: With `rom_present_n` low, `rd_req` stays high while bytes are wanted, and a byte is taken on each rising edge where `rd_req` and `rd_valid` are both high. The stream is a 16-bit count (high byte first), then that many 5-byte records: an address byte followed by a data word sent high byte first. A count of 0x0000 or 0xFFFF ends the load with no records read.
- R5: A record whose address is below NREGS writes its data word into that register, even if the register is read-only or holds the strap value. A record whose address is NREGS or above is discarded.
- R6: `link_en` stays low while `rd_req` is high. It rises on the edge that takes the final byte, or the edge that ends the load, and then stays high. `init_done` rises one edge later and stays high.
- R7: Runtime writes (`cfg_we`) are ignored until `init_done` is high. After that, a write to a register whose bit is set in RO_MASK (registers 0 and 1 by default) is ignored, and a write to any other register takes effect at the edge.
- R8: If `rd_req` is high and `rd_valid` has been low for `tmo_limit` consecutive edges, the load is abandoned. `load_err` then goes high and stays high until reset, and link bring-up proceeds. A wait of `tmo_limit`-1 edges causes no error.
- R9: `cfg_rdata` shows the register selected by `cfg_raddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Fundamental reset, active low, asynchronous |
| strap_mode | input | MODE_W | Operating-mode strap |
| strap_upport | input | UP_W | Upstream port number strap |
| strap_lanes | input | NUM_PORTS*LANE_W | Lane-width code per port |
| rom_present_n | input | 1 | Low when a configuration memory is attached |
| tmo_limit | input | TMO_W | Stall cycles that abort the load |
| rd_req | output | 1 | Sequencer wants a byte |
| rd_valid | input | 1 | Byte on rd_byte is valid |
| rd_byte | input | 8 | Byte from the memory reader |
| cfg_we | input | 1 | Runtime register write strobe |
| cfg_waddr | input | AW | Runtime write address |
| cfg_wdata | input | 32 | Runtime write data |
| cfg_raddr | input | AW | Read address |
| cfg_rdata | output | 32 | Read data |
| link_en | output | 1 | Physical layer may start link bring-up |
| init_done | output | 1 | Configuration sequence finished |
| load_err | output | 1 | Load aborted by timeout (sticky) |

## Verification
The bench sweeps every mode and upstream-port strap combination. A design that sampled the straps on the wrong edge, or sampled them again later, would show a stale or moving register 0. It loads images that overwrite the strap register and a read-only register, and images that carry an out-of-range address, a zero count or a blank count. Writing past the end of the bank, skipping read-only targets, or reading records for a blank image would each leave a register with the wrong value. It also sweeps the stall length across the timeout threshold: a design off by one would flag an error one gap too early or one too late. Finally, it sends runtime writes during the load and after it to confirm that read-only protection and the done gate are both in force.

// File: rtl/cfg_init_seq.sv
module cfg_init_seq #(
  parameter int NUM_PORTS = 4,
  parameter int LANE_W    = 3,
  parameter int MODE_W    = 2,
  parameter int UP_W      = 3,
  parameter int NREGS     = 8,
  parameter int TMO_W     = 12,
  parameter logic [NREGS-1:0] RO_MASK = 'b11,
  localparam int AW       = $clog2(NREGS),
  localparam int LANES_W  = NUM_PORTS*LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] strap_mode,
  input  logic [UP_W-1:0]   strap_upport,
  input  logic [LANES_W-1:0] strap_lanes,
  input  logic              rom_present_n,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              rd_req,
  input  logic              rd_valid,
  input  logic [7:0]        rd_byte,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_waddr,
  input  logic [31:0]       cfg_wdata,
  input  logic [AW-1:0]     cfg_raddr,
  output logic [31:0]       cfg_rdata,
  output logic              link_en,
  output logic              init_done,
  output logic              load_err
);

  localparam int STRAP_W = MODE_W + UP_W + LANES_W;

  typedef enum logic [2:0] {
    S_RESET, S_SAMPLE, S_CHECK, S_HDR, S_REC, S_LINK, S_DONE
  } st_t;

  st_t              st;
  logic [31:0]      bank [NREGS];
  logic [2:0]       bidx;
  logic [15:0]      remain;
  logic [7:0]       hold;
  logic [23:0]      sh;
  logic [TMO_W-1:0] wait_cnt;
  logic             err_q;

  wire              loading  = (st == S_HDR) || (st == S_REC);
  wire              take     = loading && rd_valid;
  wire              expire   = loading && !rd_valid && (wait_cnt == tmo_limit - 1'b1);
  wire [15:0]       hdr_cnt  = {hold, rd_byte};
  wire              rec_last = take && (st == S_REC) && (bidx == 3'd4);
  wire              rec_hit  = rec_last && (32'(hold) < NREGS);
  wire              rt_we    = cfg_we && (st == S_DONE) && !RO_MASK[cfg_waddr];
  wire [STRAP_W-1:0] strap_word = {strap_lanes, strap_upport, strap_mode};

  assign rd_req    = loading;
  assign link_en   = (st == S_LINK) || (st == S_DONE);
  assign init_done = (st == S_DONE);
  assign load_err  = err_q;
  assign cfg_rdata = bank[cfg_raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RESET;
      bidx   <= '0;
      remain <= '0;
      hold   <= '0;
      sh     <= '0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_RESET:  st <= S_SAMPLE;
        S_SAMPLE: st <= S_CHECK;
        S_CHECK: begin
          bidx <= '0;
          st   <= rom_present_n ? S_LINK : S_HDR;
        end
        S_HDR: begin
          if (expire) begin
            err_q <= 1'b1;
            st    <= S_LINK;
          end else if (take) begin
            if (bidx == 3'd0) begin
              hold <= rd_byte;
              bidx <= 3'd1;
            end else begin
              bidx <= '0;
              if (hdr_cnt == 16'h0000 || hdr_cnt == 16'hFFFF) begin
                st <= S_LINK;
              end else begin
                remain <= hdr_cnt;
                st     <= S_REC;
              end
            end
          end
        end
        S_REC: begin
          if (expire) begin
            err_q <= 1'b1;
            st    <= S_LINK;
          end else if (take) begin
            if (bidx == 3'd0) hold <= rd_byte;
            else              sh   <= {sh[15:0], rd_byte};
            if (bidx == 3'd4) begin
              bidx   <= '0;
              remain <= remain - 16'd1;
              if (remain == 16'd1) st <= S_LINK;
            end else begin
              bidx <= bidx + 3'd1;
            end
          end
        end
        S_LINK:  st <= S_DONE;
        default: st <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wait_cnt <= '0;
    else if (!loading || take)  wait_cnt <= '0;
    else if (!expire)           wait_cnt <= wait_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) bank[i] <= '0;
    end else begin
      if (st == S_SAMPLE) bank[0] <= 32'(strap_word);
      if (rec_hit)        bank[hold[AW-1:0]] <= {sh, rd_byte};
      if (rt_we)          bank[cfg_waddr] <= cfg_wdata;
    end
  end

endmodule

// File: rtl/cfg_init_seq_chk.sv
module cfg_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        link_en,
  input logic        init_done,
  input logic        load_err,
  input logic [31:0] strap_word
);

  AST_NO_LINK_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> !link_en); // R6
  AST_LINK_HELD: assert property (@(posedge clk) disable iff (!rst_n) link_en |=> link_en); // R6
  AST_DONE_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> link_en); // R6
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done); // R6
  AST_NO_REQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> !rd_req); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) load_err |=> load_err); // R8
  AST_ERR_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(load_err) |-> $past(rd_req)); // R8
  AST_STRAP_REG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $past(init_done)) |-> $stable(strap_word)); // R7

endmodule

bind cfg_init_seq cfg_init_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .link_en    (link_en),
  .init_done  (init_done),
  .load_err   (load_err),
  .strap_word (bank[0])
);

// File: tb/cfg_init_seq_test.sv
module cfg_init_seq_test;
  localparam int NP = 4, LW = 3, MW = 2, UW = 3, NR = 8, TW = 12, AW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [MW-1:0] strap_mode = 0;
  logic [UW-1:0] strap_upport = 0;
  logic [NP*LW-1:0] strap_lanes = 0;
  logic rom_present_n = 1;
  logic [TW-1:0] tmo_limit = 8;
  logic rd_req, rd_valid = 0;
  logic [7:0] rd_byte = 0;
  logic cfg_we = 0;
  logic [AW-1:0] cfg_waddr = 0, cfg_raddr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic link_en, init_done, load_err;

  cfg_init_seq uut (.*);

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic [7:0] img [0:63];
  int img_len = 0, gap = 0, ptr = 0, wcnt = 0;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr = 0; wcnt = 0; rd_valid = 0;
    end else if (rd_valid) begin
      ptr++; wcnt = 0; rd_valid = 0;
    end else if (rd_req && ptr < img_len) begin
      if (wcnt >= gap) begin rd_valid = 1; rd_byte = img[ptr]; end
      else wcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    cfg_raddr = AW'(a); #1; v = cfg_rdata;
  endtask

  task automatic start(input bit pres_n);
    logic [31:0] v;
    rst_n = 0; rom_present_n = pres_n; cfg_we = 0;
    repeat (2) @(negedge clk);
    rd(2, v);
    chk(!link_en && !init_done && !load_err && !rd_req && v == 0, "R1",
        {link_en, init_done, load_err, rd_req, v[27:0]}, 0);
    rst_n = 1;
  endtask

  task automatic wait_done(input bit rt_probe);
    bit seen = 0, checked = 0;
    for (int n = 0; n < 400 && !init_done; n++) begin
      @(negedge clk);
      if (rd_req) begin
        seen = 1;
        if (rt_probe) begin cfg_we = 1; cfg_waddr = 3; cfg_wdata = 32'h55; end
      end else begin
        cfg_we = 0;
        if (seen && !checked) begin
          checked = 1;
          chk(link_en && !init_done, "R6", {link_en, init_done}, 2'b10);
        end
      end
    end
    cfg_we = 0;
    chk(init_done, "R6", init_done, 1);
  endtask

  task automatic put_rec(input int a, input logic [31:0] d);
    img[img_len] = 8'(a); img[img_len+1] = d[31:24]; img[img_len+2] = d[23:16];
    img[img_len+3] = d[15:8]; img[img_len+4] = d[7:0]; img_len += 5;
  endtask

  task automatic put_hdr(input logic [15:0] c);
    img[0] = c[15:8]; img[1] = c[7:0]; img_len = 2;
  endtask

  initial begin
    #(4*200000);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v, expw;
    strap_mode = 1; strap_upport = 2; strap_lanes = 12'h123;
    start(1);
    for (int m = 0; m < 4; m++) begin
      for (int u = 0; u < 8; u++) begin
        logic [NP*LW-1:0] ln;
        ln = (NP*LW)'((m * 37 + u * 11) * 13 + 5);
        strap_mode = 0; strap_upport = 0; strap_lanes = 0;
        start(1);
        strap_mode = MW'(m); strap_upport = UW'(u); strap_lanes = ln;
        @(negedge clk);
        @(negedge clk);
        expw = 32'({ln, UW'(u), MW'(m)});
        strap_mode = ~MW'(m); strap_upport = ~UW'(u); strap_lanes = ~ln;
        rd(0, v);
        chk(v == expw, "R2", v, expw);
        chk(!link_en && !rd_req, "R3", {link_en, rd_req}, 0);
        @(negedge clk);
        chk(link_en && !init_done && !rd_req, "R3", {link_en, init_done}, 2'b10);
        @(negedge clk);
        chk(init_done && !load_err, "R3", {init_done, load_err}, 2'b10);
        repeat (3) @(negedge clk);
        rd(0, v);
        chk(v == expw, "R2", v, expw);
      end
    end

    strap_mode = 2; strap_upport = 5; strap_lanes = 12'hABC;
    expw = 32'({12'hABC, 3'd5, 2'd2});
    tmo_limit = 8; gap = 0;
    for (int b = 0; b < 2; b++) begin
      put_hdr(b == 0 ? 16'hFFFF : 16'h0000);
      put_rec(4, 32'hBADBAD00);
      start(0);
      wait_done(0);
      chk(ptr == 2, "R4", ptr, 2);
      rd(4, v); chk(v == 0, "R4", v, 0);
      rd(0, v); chk(v == expw, "R4", v, expw);
      chk(!load_err, "R4", load_err, 0);
    end

    put_hdr(16'd4);
    put_rec(1, 32'hA1B2C3D4);
    put_rec(0, 32'h12345678);
    put_rec(5, 32'hCAFEF00D);
    put_rec(9, 32'hDEADBEEF);
    start(0);
    wait_done(1);
    chk(!load_err && ptr == 22, "R4", ptr, 22);
    rd(1, v); chk(v == 32'hA1B2C3D4, "R5", v, 32'hA1B2C3D4);
    rd(0, v); chk(v == 32'h12345678, "R5", v, 32'h12345678);
    rd(5, v); chk(v == 32'hCAFEF00D, "R5", v, 32'hCAFEF00D);
    for (int r = 2; r < 8; r++) if (r != 5) begin
      rd(r, v); chk(v == 0, (r == 3) ? "R7" : "R5", v, 0);
    end
    @(negedge clk);
    cfg_we = 1; cfg_waddr = 0; cfg_wdata = 32'hFFFFFFFF; @(negedge clk);
    cfg_waddr = 1; cfg_wdata = 0; @(negedge clk);
    cfg_waddr = 5; cfg_wdata = 32'h11223344; @(negedge clk);
    cfg_waddr = 7; cfg_wdata = 32'h77; @(negedge clk);
    cfg_we = 0;
    rd(0, v); chk(v == 32'h12345678, "R7", v, 32'h12345678);
    rd(1, v); chk(v == 32'hA1B2C3D4, "R7", v, 32'hA1B2C3D4);
    rd(5, v); chk(v == 32'h11223344, "R7", v, 32'h11223344);
    rd(7, v); chk(v == 32'h77, "R9", v, 32'h77);

    tmo_limit = 4;
    for (int g = 0; g < 6; g++) begin
      bit exp_err;
      exp_err = (1 + g >= 4);
      gap = g;
      put_hdr(16'd1);
      put_rec(6, 32'h600D0000 + g);
      start(0);
      wait_done(0);
      chk(load_err == exp_err, "R8", load_err, 32'(exp_err));
      expw = exp_err ? 32'h0 : 32'h600D0000 + g;
      rd(6, v); chk(v == expw, "R8", v, expw);
      chk(link_en, "R8", link_en, 1);
    end

    gap = 0; tmo_limit = 4;
    put_hdr(16'd1);
    img[2] = 8'd6; img[3] = 8'h11; img_len = 4;
    start(0);
    wait_done(0);
    repeat (3) @(negedge clk);
    chk(load_err && init_done, "R8", {load_err, init_done}, 2'b11);
    rd(6, v); chk(v == 0, "R8", v, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule